// File: doc/BRIEF.md
# Odd-Ones and Double-Zero Monitor

This block watches a serial bit stream, one bit per accepted sample, and raises a single flag when two conditions are both true about everything it has accepted since reset. The number of 1 bits taken so far must be odd. Somewhere in the accepted history, two 0 bits must have arrived on consecutive accepted samples. The parity part follows every 1. The double-zero part is sticky: once a pair of adjacent zeros has been seen, it stays set until the next reset.

The machine is a Moore machine. Its state is split into a one-bit parity tracker and a three-valued zero tracker. The zero tracker has three values: clear, last accepted bit was 0, and pair seen. A parameter picks a binary or a one-hot encoding for the zero tracker. Bits are taken only on rising clock edges where the valid strobe is high, and the state holds on every other edge. The flag is a flop. It is loaded from the decoded next state, so it changes on the same edge as the state that it reflects.

Top module: `oddz_mon`

## Requirements
- R1: On a clock edge with `rst` high, parity returns to even, the zero tracker returns to clear, and `flag_out` is 0 after that edge. `rst` takes priority over `bit_vld`.
- R2: A bit accepted on a rising edge (`bit_vld` high, `rst` low) is already reflected in `flag_out` right after that same edge.
- R3: On an edge with `bit_vld` low, `bit_in` has no effect. `flag_out` and the tracked history are unchanged, and later results are as if that cycle never happened.
- R4: `flag_out` is 1 only while the count of accepted 1 bits is odd. An accepted 0 never changes the parity.
- R5: `flag_out` is 1 only after two 0 bits have been accepted on consecutive accepted samples. Edges without a valid bit between them do not break the adjacency.
- R6: Once a zero pair has been seen, later accepted 1 bits do not clear that condition before a reset.
- R7: An accepted 1 between two accepted 0 bits breaks the pairing, so the input 0,1,0 does not count as a zero pair.
- R8: After a zero pair has been seen, each accepted 1 toggles `flag_out`, and accepted 0 bits leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | High when `bit_in` holds a bit to accept on this edge |
| bit_in | input | 1 | Serial data bit |
| flag_out | output | 1 | Registered flag: odd count of ones and a zero pair seen |

## Verification
The bench goes after the sequence 0,1,0. A tracker that fails to clear its "last was zero" memory on a 1 would wrongly raise the flag there. It sends pairs of zeros with invalid cycles in between, which catches a design that samples `bit_in` without looking at `bit_vld` or that resets adjacency on idle edges. It sends long runs of 1s after a pair, which exposes a zero flag that is not sticky, and even-count streams, which expose a parity that is lost or tied to 0 bits. It also asserts reset together with a valid 1 bit, to catch a design that lets the sample beat the reset.

// File: rtl/oddz_pkg.sv
package oddz_pkg;

  // zero-tracking progress of the monitor
  typedef enum logic [1:0] {
    ZT_CLEAR = 2'd0,
    ZT_HALF  = 2'd1,
    ZT_PAIR  = 2'd2
  } zt_e;

  localparam int ZT_STATES = 3;

  // advance the zero tracker by one accepted bit
  function automatic zt_e zt_step(zt_e cur, logic bit_v);
    zt_e nxt;
    if (cur == ZT_PAIR) begin
      nxt = ZT_PAIR;
    end else if (bit_v) begin
      nxt = ZT_CLEAR;
    end else if (cur == ZT_HALF) begin
      nxt = ZT_PAIR;
    end else begin
      nxt = ZT_HALF;
    end
    return nxt;
  endfunction

  // parity of ones after one accepted bit
  function automatic logic par_step(logic cur, logic bit_v);
    return cur ^ bit_v;
  endfunction

  // Moore output decode
  function automatic logic flag_decode(logic odd, logic pair);
    return odd & pair;
  endfunction

endpackage

// File: rtl/oddz_par_trk.sv
module oddz_par_trk
  import oddz_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic bit_v,
  output logic odd_q,
  output logic odd_nxt
);

  always_comb begin
    odd_nxt = odd_q;
    if (take) odd_nxt = par_step(odd_q, bit_v);
  end

  always_ff @(posedge clk) begin
    if (rst) odd_q <= 1'b0;
    else     odd_q <= odd_nxt;
  end

endmodule

// File: rtl/oddz_zero_trk.sv
module oddz_zero_trk
  import oddz_pkg::*;
#(
  parameter bit ONEHOT = 1'b0
)(
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic bit_v,
  output logic pair_q,
  output logic pair_nxt,
  output logic half_q
);

  zt_e cur_s;
  zt_e nxt_s;

  always_comb begin
    nxt_s = cur_s;
    if (take) nxt_s = zt_step(cur_s, bit_v);
  end

  generate
    if (ONEHOT) begin : g_onehot
      localparam int W = ZT_STATES;
      logic [W-1:0] oh_q;
      logic [W-1:0] oh_d;

      always_comb begin
        if (oh_q[2])      cur_s = ZT_PAIR;
        else if (oh_q[1]) cur_s = ZT_HALF;
        else              cur_s = ZT_CLEAR;
      end

      always_comb begin
        case (nxt_s)
          ZT_PAIR: oh_d = 3'b100;
          ZT_HALF: oh_d = 3'b010;
          default: oh_d = 3'b001;
        endcase
      end

      always_ff @(posedge clk) begin
        if (rst) oh_q <= 3'b001;
        else     oh_q <= oh_d;
      end
    end else begin : g_binary
      zt_e bin_q;
      assign cur_s = bin_q;

      always_ff @(posedge clk) begin
        if (rst) bin_q <= ZT_CLEAR;
        else     bin_q <= nxt_s;
      end
    end
  endgenerate

  assign pair_q   = (cur_s == ZT_PAIR);
  assign half_q   = (cur_s == ZT_HALF);
  assign pair_nxt = (nxt_s == ZT_PAIR);

endmodule

// File: rtl/oddz_mon.sv
module oddz_mon
  import oddz_pkg::*;
#(
  parameter bit ZT_ONEHOT = 1'b0
)(
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  output logic flag_out
);

  // named internal events for the checker
  logic sample_evt;
  logic par_odd;
  logic par_odd_nxt;
  logic pair_seen;
  logic pair_nxt;
  logic half_seen;
  logic flag_q;

  assign sample_evt = bit_vld & ~rst;

  oddz_par_trk par_i (
    .clk     (clk),
    .rst     (rst),
    .take    (sample_evt),
    .bit_v   (bit_in),
    .odd_q   (par_odd),
    .odd_nxt (par_odd_nxt)
  );

  oddz_zero_trk #(.ONEHOT(ZT_ONEHOT)) zero_i (
    .clk      (clk),
    .rst      (rst),
    .take     (sample_evt),
    .bit_v    (bit_in),
    .pair_q   (pair_seen),
    .pair_nxt (pair_nxt),
    .half_q   (half_seen)
  );

  // output flop loaded from the next state: tracks present state exactly
  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_decode(par_odd_nxt, pair_nxt);
  end

  assign flag_out = flag_q;

endmodule

// File: rtl/oddz_mon_chk.sv
module oddz_mon_chk (
  input logic clk,
  input logic rst,
  input logic bit_vld,
  input logic bit_in,
  input logic flag_out,
  input logic par_odd,
  input logic pair_seen,
  input logic half_seen
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!flag_out && !par_odd && !pair_seen)); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !bit_vld |=> ($stable(flag_out) && $stable(par_odd) && $stable(pair_seen) && $stable(half_seen))); // R3
  AST_FLAG_NEEDS_ODD: assert property (@(posedge clk) disable iff (rst) flag_out |-> par_odd); // R4
  AST_ZERO_KEEPS_PARITY: assert property (@(posedge clk) disable iff (rst) (bit_vld && !bit_in) |=> $stable(par_odd)); // R4
  AST_FLAG_NEEDS_PAIR: assert property (@(posedge clk) disable iff (rst) flag_out |-> pair_seen); // R5
  AST_PAIR_STICKY: assert property (@(posedge clk) disable iff (rst) pair_seen |=> pair_seen); // R6
  AST_ONE_BREAKS_HALF: assert property (@(posedge clk) disable iff (rst) (bit_vld && bit_in && !pair_seen) |=> !half_seen); // R7
  AST_PAIR_FROM_ZERO: assert property (@(posedge clk) disable iff (rst) $rose(pair_seen) |-> $past(bit_vld && !bit_in && half_seen)); // R7
  AST_ONE_TOGGLES_FLAG: assert property (@(posedge clk) disable iff (rst) (bit_vld && bit_in && pair_seen) |=> (flag_out != $past(flag_out))); // R8

endmodule

bind oddz_mon oddz_mon_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .bit_vld   (bit_vld),
  .bit_in    (bit_in),
  .flag_out  (flag_out),
  .par_odd   (par_odd),
  .pair_seen (pair_seen),
  .half_seen (half_seen)
);

// File: tb/oddz_mon_tb_top.sv
`timescale 1ns/1ps
module oddz_mon_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic flag_out;

  always #2.5 clk = ~clk;

  oddz_mon dut_i (
    .clk      (clk),
    .rst      (rst),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .flag_out (flag_out)
  );

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // independent reference: count ones, remember previous zero, latch pair
  int ones_cnt = 0;
  bit prev_zero = 1'b0;
  bit pair_hit = 1'b0;

  function automatic logic model_flag();
    return (ones_cnt % 2 == 1) && pair_hit;
  endfunction

  task automatic send(input logic v, input logic b, input string tag);
    item_t it;
    @(negedge clk);
    rst = 1'b0;
    bit_vld = v;
    bit_in = b;
    if (v) begin
      if (b) begin
        ones_cnt++;
        prev_zero = 1'b0;
      end else begin
        if (prev_zero) pair_hit = 1'b1;
        prev_zero = 1'b1;
      end
    end
    it.exp = model_flag();
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic do_reset(input logic v, input logic b);
    item_t it;
    @(negedge clk);
    rst = 1'b1;
    bit_vld = v;
    bit_in = b;
    ones_cnt = 0;
    prev_zero = 1'b0;
    pair_hit = 1'b0;
    it.exp = 1'b0;
    it.tag = "R1";
    sb_q.push_back(it);
  endtask

  // monitor: compare one item per edge, after outputs settle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_cmp++;
        if (flag_out !== it.exp) begin
          n_bad++;
          $display("FAIL %s: flag_out=%b expected=%b at %0t", it.tag, flag_out, it.exp, $time);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    do_reset(1'b0, 1'b0);                  // R1 reset state
    // R5 + R2: 1 then 0,0 -> odd and pair, visible on the accepting edge
    send(1, 1, "R2");
    send(1, 0, "R5");
    send(1, 0, "R2");
    // R8: ones toggle after the pair, zeros leave it
    send(1, 1, "R8");
    send(1, 0, "R8");
    send(1, 1, "R8");
    send(1, 1, "R6");
    send(1, 1, "R6");
    // R3: idle edges with data wiggling
    send(0, 1, "R3");
    send(0, 0, "R3");
    send(0, 1, "R3");
    send(1, 1, "R3");
    // R7: 0,1,0 is not a pair
    do_reset(1'b0, 1'b0);
    send(1, 0, "R7");
    send(1, 1, "R7");
    send(1, 0, "R7");
    send(1, 1, "R7");
    send(1, 1, "R7");                       // odd again, still no pair
    send(1, 0, "R5");
    send(1, 0, "R5");                       // pair formed, ones=3 odd
    // R5: zeros separated by idle edges still pair
    do_reset(1'b0, 1'b0);
    send(1, 1, "R5");
    send(1, 0, "R5");
    send(0, 1, "R3");
    send(0, 1, "R3");
    send(1, 0, "R5");
    // R4: pair seen but even ones
    do_reset(1'b0, 1'b0);
    send(1, 0, "R4");
    send(1, 0, "R4");
    send(1, 1, "R4");
    send(1, 1, "R4");
    send(1, 0, "R4");
    send(1, 1, "R4");
    // R1: reset beats a valid 1 bit
    do_reset(1'b1, 1'b1);
    send(1, 0, "R1");
    send(1, 0, "R1");
    send(0, 0, "R1");
    // mixed stream
    do_reset(1'b0, 1'b0);
    lfsr = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      send(lfsr[0] | lfsr[3], lfsr[5] & lfsr[6] | lfsr[2], "R8");
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    @(negedge clk);
    bit_vld = 1'b0;
    while (sb_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule